// File: doc/BRIEF.md
# Soft-Start and Hiccup Sequencer

This block is the digital sequencer of a synchronous buck controller. A ramp counter stands in for the charge on a soft-start capacitor. Each clock in which `tick` is high, the ramp rises by a fixed step. Threshold compares on the ramp then release the switching stage in stages. First the low-side switch is enabled, which discharges the output. At a higher level the high-side switch is also allowed to switch. Once the output reports that it has reached its target, the error-amplifier clamp is released and the block enters normal operation.

The block protects the stage in three ways. A supply-good flag that drops, or an inhibit request, clears the ramp at once and keeps both switches off. An over-current report does not latch the converter off. Instead both switches are turned off, the ramp is left to rise to its ceiling, and it then falls at a slow constant rate. When it reaches the low-side level, a new soft start begins. This retry loop repeats for as long as the fault persists. The hiccup flag is cleared by a completed soft start or by a supply or inhibit reset, so the converter recovers without a power cycle.

Top module: `softstart_seq`

## Requirements
- R1: While `rst_n` is low on a clock edge, the block returns to its idle state: `ramp` is 0 and `ls_en`, `hs_en`, `clamp_rel` and `hiccup` are all 0.
- R2: During a soft start, in normal running and during the rising part of a fault, each edge with `tick` high adds `CHG_STEP` to `ramp`. The ramp saturates at `TOP_LVL` and never exceeds it.
- R3: `ls_en` is 1 exactly when the block is soft-starting or running and `ramp` >= `LS_LVL`.
- R4: `hs_en` is 1 exactly when the block is soft-starting or running and `ramp` >= `HS_LVL`. `hs_en` is never 1 while `ls_en` is 0.
- R5: If `vcc_ok` or `ocs_ok` is 0 at an edge, then after that edge `ramp` is 0, all four outputs are 0, and any hiccup status is cleared. No start-up happens while either flag is 0.
- R6: `inhibit` high at an edge has the same effect as a supply loss: `ramp` becomes 0 and both switch enables are off for as long as `inhibit` is held.
- R7: `oc_flag` high at an edge while soft-starting or running turns off `ls_en`, `hs_en` and `clamp_rel` after that edge, and sets `hiccup` to 1.
- R8: After an over-current trip, `ramp` keeps rising to `TOP_LVL`. From one cycle after it reaches `TOP_LVL`, it falls by `DIS_STEP` on each tick, with both switches off.
- R9: When the falling ramp reaches `LS_LVL`, a new soft start begins from that level on the next edge, with `ls_en` on. The cycle repeats if the over-current recurs.
- R10: `at_target` high at an edge during a soft start with `ramp` >= `HS_LVL` sets `clamp_rel` after that edge and clears `hiccup`. `clamp_rel` stays 1 until a trip, supply loss or inhibit. `at_target` has no effect while `ramp` < `HS_LVL`.
- R11: An edge with `tick` low leaves `ramp` unchanged unless a supply loss or inhibit clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | Ramp step enable |
| vcc_ok | input | 1 | Main supply above its turn-on level |
| ocs_ok | input | 1 | Over-current sense rail above its turn-on level |
| oc_flag | input | 1 | Over-current detected |
| inhibit | input | 1 | External request to hold the converter off |
| at_target | input | 1 | Output voltage has reached its set point |
| ramp | output | RAMP_W | Emulated soft-start level in counter units |
| ls_en | output | 1 | Low-side switch enable |
| hs_en | output | 1 | High-side switching enable |
| clamp_rel | output | 1 | Error-amplifier clamp released (soft start complete) |
| hiccup | output | 1 | Over-current retry in progress |

## Verification
A wrong internal state shows up within one clock, because every output is decoded from the state register and the ramp value on that edge. A stuck state or a bad ramp step appears as a `ramp` value that is off by one step, or as an enable that leads or lags its threshold by exactly one tick. A missed transition between the rising and falling parts of a fault is visible at the ports. It shows as a ramp that stays at its ceiling, or as a restart that never turns `ls_en` back on. The bench therefore compares `ramp` and all four flags against an independent model on every cycle. It also pins the threshold edges, the hold on a low `tick`, and each forced-off path.

// File: rtl/ssq_pkg.sv
// Shared types of the soft-start sequencer: controller state and ramp command.
package ssq_pkg;

    typedef enum logic [2:0] {
        SQ_OFF     = 3'd0,
        SQ_START   = 3'd1,
        SQ_RUN     = 3'd2,
        SQ_TRIP_UP = 3'd3,
        SQ_TRIP_DN = 3'd4
    } sq_state_t;

    typedef enum logic [1:0] {
        RC_HOLD  = 2'd0,
        RC_CLEAR = 2'd1,
        RC_UP    = 2'd2,
        RC_DOWN  = 2'd3
    } ramp_cmd_t;

endpackage

// File: rtl/ssq_ramp.sv
// Ramp counter emulating the soft-start capacitor.
// Rises by CHG on each tick when commanded up, saturating at CEIL.
// Falls by DIS on each tick when commanded down, stopping at FLOOR.
// Assumes a down command is only issued while ramp >= FLOOR.
module ssq_ramp
    import ssq_pkg::*;
#(
    parameter int          W     = 10,
    parameter int unsigned CHG   = 2,
    parameter int unsigned DIS   = 1,
    parameter int unsigned CEIL  = 400,
    parameter int unsigned FLOOR = 50
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  ramp_cmd_t       cmd,
    output logic [W-1:0]    ramp
);

    logic [W-1:0] ramp_d;
    int unsigned  cur_v;
    int unsigned  up_v;

    // Next ramp level for the current command.
    always_comb begin
        cur_v  = 32'(ramp);
        up_v   = cur_v + CHG;
        ramp_d = ramp;
        unique case (cmd)
            RC_CLEAR: ramp_d = '0;
            RC_UP: begin
                if (tick) begin
                    ramp_d = (up_v >= CEIL) ? W'(CEIL) : W'(up_v);
                end
            end
            RC_DOWN: begin
                if (tick) begin
                    ramp_d = (cur_v >= FLOOR + DIS) ? W'(cur_v - DIS) : W'(FLOOR);
                end
            end
            default: ramp_d = ramp;
        endcase
    end

    // Ramp register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ramp <= '0;
        end else begin
            ramp <= ramp_d;
        end
    end

    AST_RAMP_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
        32'(ramp) <= CEIL);                                                     // R2
    AST_RAMP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && cmd != RC_CLEAR) |=> $stable(ramp));                          // R11
    AST_RAMP_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == RC_DOWN && tick && 32'(ramp) > FLOOR) |=> ramp < $past(ramp));  // R8
    AST_RAMP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == RC_CLEAR) |=> ramp == '0);                                      // R5

endmodule

// File: rtl/ssq_level.sv
// Threshold compares of the ramp against the low-side, high-side and ceiling levels.
// Index 0 is the low-side level, 1 the high-side level, 2 the ceiling.
// Assumes the three levels ascend.
module ssq_level #(
    parameter int          W   = 10,
    parameter int unsigned LS  = 50,
    parameter int unsigned HS  = 100,
    parameter int unsigned TOP = 400
) (
    input  logic [W-1:0] ramp,
    output logic [2:0]   ge,
    output logic [2:0]   eq
);

    localparam int unsigned NLVL = 3;
    localparam int unsigned LVL [NLVL] = '{LS, HS, TOP};

    // One comparator pair per level.
    for (genvar g = 0; g < NLVL; g++) begin : g_cmp
        assign ge[g] = (32'(ramp) >= LVL[g]);
        assign eq[g] = (32'(ramp) == LVL[g]);
    end

endmodule

// File: rtl/ssq_fsm.sv
// Sequencing state machine. Chooses the ramp command and tracks hiccup status.
// Supply loss and inhibit take priority over over-current, which takes priority over completion.
module ssq_fsm
    import ssq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      vcc_ok,
    input  logic      ocs_ok,
    input  logic      inhibit,
    input  logic      oc_flag,
    input  logic      at_target,
    input  logic      ge_hs,
    input  logic      eq_ls,
    input  logic      eq_top,
    output sq_state_t state,
    output ramp_cmd_t cmd,
    output logic      hiccup
);

    sq_state_t state_d;
    logic      hic_d;
    logic      forced_off;

    assign forced_off = !vcc_ok || !ocs_ok || inhibit;

    // Next state, next hiccup flag and the ramp command for this cycle.
    always_comb begin
        state_d = state;
        hic_d   = hiccup;
        cmd     = RC_HOLD;
        if (forced_off) begin
            state_d = SQ_OFF;
            hic_d   = 1'b0;
            cmd     = RC_CLEAR;
        end else begin
            unique case (state)
                SQ_OFF: state_d = SQ_START;
                SQ_START: begin
                    cmd = RC_UP;
                    if (oc_flag) begin
                        state_d = SQ_TRIP_UP;
                        hic_d   = 1'b1;
                    end else if (at_target && ge_hs) begin
                        state_d = SQ_RUN;
                        hic_d   = 1'b0;
                    end
                end
                SQ_RUN: begin
                    cmd = RC_UP;
                    if (oc_flag) begin
                        state_d = SQ_TRIP_UP;
                        hic_d   = 1'b1;
                    end
                end
                SQ_TRIP_UP: begin
                    cmd = RC_UP;
                    if (eq_top) state_d = SQ_TRIP_DN;
                end
                SQ_TRIP_DN: begin
                    cmd = RC_DOWN;
                    if (eq_ls) state_d = SQ_START;
                end
                default: state_d = SQ_OFF;
            endcase
        end
    end

    // State and hiccup registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= SQ_OFF;
            hiccup <= 1'b0;
        end else begin
            state  <= state_d;
            hiccup <= hic_d;
        end
    end

    AST_TRIP_TURNS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_TRIP_UP && eq_top && !forced_off) |=> state == SQ_TRIP_DN);  // R8
    AST_RESTART_AT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_TRIP_DN && eq_ls && !forced_off) |=> state == SQ_START);     // R9
    AST_TRIP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_TRIP_UP || state == SQ_TRIP_DN) |-> hiccup);                 // R7

endmodule

// File: rtl/softstart_seq.sv
// Soft-start and hiccup sequencer top.
// The ramp counter emulates the soft-start capacitor. The threshold compares stage the
// low-side and high-side enables. The state machine handles supply loss, inhibit and
// over-current retry. Outputs are decoded from registered state and ramp only.
module softstart_seq
    import ssq_pkg::*;
#(
    parameter int          RAMP_W   = 10,
    parameter int unsigned CHG_STEP = 2,
    parameter int unsigned DIS_STEP = 1,
    parameter int unsigned LS_LVL   = 50,
    parameter int unsigned HS_LVL   = 100,
    parameter int unsigned TOP_LVL  = 400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              vcc_ok,
    input  logic              ocs_ok,
    input  logic              oc_flag,
    input  logic              inhibit,
    input  logic              at_target,
    output logic [RAMP_W-1:0] ramp,
    output logic              ls_en,
    output logic              hs_en,
    output logic              clamp_rel,
    output logic              hiccup
);

    localparam int IDX_LS  = 0;
    localparam int IDX_HS  = 1;
    localparam int IDX_TOP = 2;

    sq_state_t state;
    ramp_cmd_t cmd;
    logic [2:0] ge;
    logic [2:0] eq;
    logic       active;

    ssq_ramp #(
        .W(RAMP_W), .CHG(CHG_STEP), .DIS(DIS_STEP), .CEIL(TOP_LVL), .FLOOR(LS_LVL)
    ) ramp_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cmd(cmd), .ramp(ramp)
    );

    ssq_level #(
        .W(RAMP_W), .LS(LS_LVL), .HS(HS_LVL), .TOP(TOP_LVL)
    ) level_i (
        .ramp(ramp), .ge(ge), .eq(eq)
    );

    ssq_fsm fsm_i (
        .clk(clk), .rst_n(rst_n), .vcc_ok(vcc_ok), .ocs_ok(ocs_ok),
        .inhibit(inhibit), .oc_flag(oc_flag), .at_target(at_target),
        .ge_hs(ge[IDX_HS]), .eq_ls(eq[IDX_LS]), .eq_top(eq[IDX_TOP]),
        .state(state), .cmd(cmd), .hiccup(hiccup)
    );

    // Output decode: switches only while starting or running.
    assign active    = (state == SQ_START) || (state == SQ_RUN);
    assign ls_en     = active && ge[IDX_LS];
    assign hs_en     = active && ge[IDX_HS];
    assign clamp_rel = (state == SQ_RUN);

    AST_HS_NEEDS_LS: assert property (@(posedge clk) disable iff (!rst_n)
        hs_en |-> ls_en);                                                          // R4
    AST_CLAMP_NEEDS_HS: assert property (@(posedge clk) disable iff (!rst_n)
        clamp_rel |-> hs_en);                                                      // R10
    AST_OC_CUTS: assert property (@(posedge clk) disable iff (!rst_n)
        (oc_flag && active && vcc_ok && ocs_ok && !inhibit)
        |=> (!ls_en && !hs_en && !clamp_rel && hiccup));                           // R7
    AST_SUPPLY_CUTS: assert property (@(posedge clk) disable iff (!rst_n)
        (!vcc_ok || !ocs_ok) |=> (ramp == '0 && !ls_en && !hs_en && !hiccup));     // R5
    AST_INHIBIT_CUTS: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit |=> (ramp == '0 && !ls_en && !hs_en));                             // R6

endmodule

// File: tb/softstart_seq_tb.sv
// Scoreboard bench: the driver pushes expected outputs from a requirement model,
// the monitor pops and compares at each falling edge.
module softstart_seq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int W   = 10;
    localparam int CHG = 2;
    localparam int DIS = 1;
    localparam int LS  = 50;
    localparam int HS  = 100;
    localparam int TOP = 400;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0, vcc_ok = 1'b0, ocs_ok = 1'b0, oc_flag = 1'b0;
    logic inhibit = 1'b0, at_target = 1'b0;
    logic [W-1:0] ramp;
    logic ls_en, hs_en, clamp_rel, hiccup;

    always #(CLK_PERIOD/2) clk = ~clk;

    softstart_seq #(
        .RAMP_W(W), .CHG_STEP(CHG), .DIS_STEP(DIS),
        .LS_LVL(LS), .HS_LVL(HS), .TOP_LVL(TOP)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .vcc_ok(vcc_ok), .ocs_ok(ocs_ok),
        .oc_flag(oc_flag), .inhibit(inhibit), .at_target(at_target),
        .ramp(ramp), .ls_en(ls_en), .hs_en(hs_en), .clamp_rel(clamp_rel), .hiccup(hiccup)
    );

    typedef struct packed {
        logic [W-1:0] r;
        logic ls, hs, cl, hc;
    } exp_t;

    exp_t exp_q[$];
    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    // Requirement model: 0 off, 1 start, 2 run, 3 trip rising, 4 trip falling.
    int m_st = 0;
    int m_r = 0;
    bit m_hc = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic model_step();
        int cmd; // 0 hold, 1 clear, 2 up, 3 down
        cmd = 0;
        if (!vcc_ok || !ocs_ok || inhibit) begin
            m_st = 0; m_hc = 1'b0; cmd = 1;
        end else begin
            case (m_st)
                0: m_st = 1;
                1: begin
                    cmd = 2;
                    if (oc_flag) begin m_st = 3; m_hc = 1'b1; end
                    else if (at_target && m_r >= HS) begin m_st = 2; m_hc = 1'b0; end
                end
                2: begin
                    cmd = 2;
                    if (oc_flag) begin m_st = 3; m_hc = 1'b1; end
                end
                3: begin cmd = 2; if (m_r == TOP) m_st = 4; end
                default: begin cmd = 3; if (m_r == LS) m_st = 1; end
            endcase
        end
        if (cmd == 1) m_r = 0;
        else if (cmd == 2 && tick) m_r = (m_r + CHG >= TOP) ? TOP : m_r + CHG;
        else if (cmd == 3 && tick) m_r = (m_r >= LS + DIS) ? m_r - DIS : LS;
    endtask

    // One clock: model, edge, expectation, then rest at the falling edge.
    task automatic cyc();
        exp_t e;
        bit act;
        model_step();
        @(posedge clk);
        act = (m_st == 1 || m_st == 2);
        e.r  = W'(m_r);
        e.ls = act && (m_r >= LS);
        e.hs = act && (m_r >= HS);
        e.cl = (m_st == 2);
        e.hc = m_hc;
        exp_q.push_back(e);
        @(negedge clk);
    endtask

    task automatic run_to(input int v);
        for (int i = 0; i < 2000 && int'(ramp) != v; i++) cyc();
        chk(int'(ramp) == v, "R2 ramp reach", int'(ramp), v);
    endtask

    // Monitor: pop and compare every expected item.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            chk(ramp == e.r, "R2 ramp", int'(ramp), int'(e.r));
            chk(ls_en == e.ls, "R3 ls_en", int'(ls_en), int'(e.ls));
            chk(hs_en == e.hs, "R4 hs_en", int'(hs_en), int'(e.hs));
            chk(clamp_rel == e.cl, "R10 clamp_rel", int'(clamp_rel), int'(e.cl));
            chk(hiccup == e.hc, "R7 hiccup", int'(hiccup), int'(e.hc));
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        int v;
        // R1: reset state.
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk({ls_en, hs_en, clamp_rel, hiccup} == 4'b0 && ramp == '0, "R1 reset outputs",
            int'({ls_en, hs_en, clamp_rel, hiccup}) + int'(ramp), 0);
        rst_n = 1'b1;

        // R5: one supply missing keeps everything off.
        vcc_ok = 1'b1; tick = 1'b1;
        repeat (6) cyc();
        chk(ramp == '0 && !ls_en, "R5 no start without ocs_ok", int'(ramp), 0);
        ocs_ok = 1'b1;

        // R3/R4 threshold edges.
        run_to(LS - CHG);
        chk(!ls_en, "R3 below level", int'(ls_en), 0);
        cyc();
        chk(ls_en && !hs_en, "R3 at level", int'(ls_en), 1);
        // R10: target ignored below high-side level.
        at_target = 1'b1; cyc(); at_target = 1'b0;
        chk(!clamp_rel, "R10 target ignored low", int'(clamp_rel), 0);
        run_to(HS - CHG);
        chk(!hs_en, "R4 below level", int'(hs_en), 0);
        cyc();
        chk(hs_en, "R4 at level", int'(hs_en), 1);

        // R11: ramp holds with tick low.
        tick = 1'b0; v = int'(ramp);
        repeat (8) cyc();
        chk(int'(ramp) == v, "R11 hold", int'(ramp), v);
        tick = 1'b1;

        // R10: completion.
        at_target = 1'b1; cyc(); at_target = 1'b0;
        chk(clamp_rel && !hiccup, "R10 clamp release", int'(clamp_rel), 1);
        repeat (5) cyc();
        chk(clamp_rel, "R10 clamp stays", int'(clamp_rel), 1);

        // R7/R8/R9: trip from running.
        oc_flag = 1'b1; cyc(); oc_flag = 1'b0;
        chk(!ls_en && !hs_en && hiccup && !clamp_rel, "R7 trip",
            int'({ls_en, hs_en, hiccup}), 1);
        run_to(TOP);
        chk(!ls_en, "R8 off at ceiling", int'(ls_en), 0);
        repeat (4) cyc();
        chk(int'(ramp) == TOP - 3 * DIS, "R8 slow fall", int'(ramp), TOP - 3 * DIS);
        run_to(LS);
        cyc();
        chk(ls_en && int'(ramp) == LS, "R9 restart level", int'(ramp), LS);
        cyc();
        chk(int'(ramp) == LS + CHG && hiccup, "R9 ramp rises", int'(ramp), LS + CHG);

        // R9: repeated retry.
        oc_flag = 1'b1; cyc(); oc_flag = 1'b0;
        chk(!ls_en && hiccup, "R9 second trip", int'(ls_en), 0);
        run_to(TOP);
        run_to(LS);
        run_to(HS);
        at_target = 1'b1; cyc(); at_target = 1'b0;
        chk(clamp_rel && !hiccup, "R10 hiccup cleared", int'(hiccup), 0);

        // R6: inhibit.
        inhibit = 1'b1; cyc();
        chk(ramp == '0 && !ls_en && !hs_en, "R6 inhibit", int'(ramp), 0);
        repeat (3) cyc();
        chk(ramp == '0 && !hs_en, "R6 inhibit held", int'(ramp), 0);
        inhibit = 1'b0;

        // R5: supply losses mid operation.
        run_to(HS + 20);
        vcc_ok = 1'b0; cyc();
        chk(ramp == '0 && !ls_en && !hs_en, "R5 vcc loss", int'(ramp), 0);
        vcc_ok = 1'b1;
        run_to(60);
        oc_flag = 1'b1; cyc(); oc_flag = 1'b0;
        repeat (3) cyc();
        ocs_ok = 1'b0; cyc();
        chk(ramp == '0 && !hiccup, "R5 ocs loss clears hiccup", int'(hiccup), 0);
        ocs_ok = 1'b1;
        repeat (4) cyc();

        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule